// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block produces the setting word for a transmit power amplifier. It reads the word from a small table that software programs. When a transmission starts, it steps through the table from entry 0 up to a chosen final entry. It then holds that final entry for as long as the transmission lasts. When the transmission ends, it steps back down through the same entries to entry 0, and the output then goes to zero. The shape of the ramp is therefore whatever the table holds. Each step is held for a programmable number of cycles.

The table is written through a plain parallel port that has two modes:
- A single write (burst flag low) always lands in entry 0.
- A burst (burst flag held high) fills consecutive entries from entry 0 upward.

A final index of zero turns the ramp off, and entry 0 is then driven for the whole transmission. Two flags report the ramp state:
- A level flag is high while the sequencer sits at full power.
- A one-cycle pulse marks the end of the ramp-down.

Top module: `pa_ramp_seq`

## Requirements
- R1: After reset the table holds zeros, and `pa_code`, `ramp_up_done` and `ramp_down_done` are all 0. While no transmission is active, `pa_code` is 0.
- R2: A write with `wr_burst` low stores `wr_data` into entry 0 only, and every other entry keeps its value.
- R3: While `wr_burst` is high, each `wr_en` cycle stores into the next entry, starting at entry 0. Lowering `wr_burst` returns the pointer to entry 0. A write after entry 7 wraps to entry 0.
- R4: A `tx_start` pulse captures `final_idx` and `step_hold`. From the next cycle, entries 0 to `final_idx`-1 are driven in ascending order, each for `step_hold`+1 cycles, and then entry `final_idx` is held.
- R5: `ramp_up_done` is high exactly while the final entry is being held. A `tx_start` during a transmission is ignored.
- R6: A `tx_end` pulse at full power starts the ramp-down. The current entry and each lower entry down to 0 are driven for `step_hold`+1 cycles each. The block then returns to idle, with `pa_code` 0 and `ramp_down_done` high for exactly one cycle.
- R7: With a captured final index of 0, entry 0 is driven and `ramp_up_done` is high from the cycle after `tx_start`. A `tx_end` returns the block to idle on the next cycle with a `ramp_down_done` pulse.
- R8: A `tx_end` during the ramp-up starts the ramp-down from the entry being driven at that moment. That entry is held for `step_hold`+1 cycles, and the descent continues as in R6.
- R9: While idle, `tx_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_burst | input | 1 | High: burst write with an auto-increment pointer; low: single write to entry 0 |
| wr_data | input | CODE_W | Power code to store |
| final_idx | input | IDX_W | Index of the full-power entry, captured at `tx_start` |
| step_hold | input | HOLD_W | Extra cycles per ramp step, captured at `tx_start` |
| tx_start | input | 1 | Start-of-transmit pulse |
| tx_end | input | 1 | End-of-transmit pulse |
| pa_code | output | CODE_W | Power amplifier setting word |
| ramp_up_done | output | 1 | High while the final entry is held |
| ramp_down_done | output | 1 | One-cycle pulse when the ramp-down finishes |

## Verification
The embedded assertions check the following on every cycle:
- The index moves by at most one step per cycle: up during the ramp-up and down during the ramp-down.
- The index never passes the captured final entry.
- The done pulse occurs only on the cycle of return to idle.
- A single write lands in entry 0.
- The burst pointer restarts whenever the burst flag is low.

Only the bench scenarios can show the full ordered sequences of codes and the exact step durations. The same goes for the zero-index case, the early abort, the wrap of a long burst, and the fact that a single write leaves the upper entries untouched.

// File: rtl/pa_ramp_seq.sv
module pa_ramp_seq #(
  parameter int IDX_W  = 3,
  parameter int CODE_W = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_burst,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  final_idx,
  input  logic [HOLD_W-1:0] step_hold,
  input  logic              tx_start,
  input  logic              tx_end,
  output logic [CODE_W-1:0] pa_code,
  output logic              ramp_up_done,
  output logic              ramp_down_done
);
  localparam int ENTRIES = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_UP, S_FULL, S_DOWN} st_t;

  st_t               st;
  logic [CODE_W-1:0] ptab [ENTRIES];
  logic [IDX_W-1:0]  ptr, idx, fin_q;
  logic [HOLD_W-1:0] hold_q, cnt;
  logic              done_q;

  wire step_end = (cnt == hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ptab[i] <= '0;
    end else if (wr_en) begin
      ptab[wr_burst ? ptr : '0] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (!wr_burst) ptr <= '0;
    else if (wr_en)    ptr <= ptr + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      fin_q  <= '0;
      hold_q <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (tx_start) begin
          fin_q  <= final_idx;
          hold_q <= step_hold;
          idx    <= '0;
          cnt    <= '0;
          st     <= (final_idx == '0) ? S_FULL : S_UP;
        end
        S_UP: begin
          if (tx_end) begin
            st  <= S_DOWN;
            cnt <= '0;
          end else if (step_end) begin
            cnt <= '0;
            idx <= idx + IDX_W'(1);
            if (idx + IDX_W'(1) == fin_q) st <= S_FULL;
          end else begin
            cnt <= cnt + HOLD_W'(1);
          end
        end
        S_FULL: if (tx_end) begin
          cnt <= '0;
          if (idx == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_DOWN;
          end
        end
        S_DOWN: begin
          if (step_end) begin
            cnt <= '0;
            if (idx == '0) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx - IDX_W'(1);
            end
          end else begin
            cnt <= cnt + HOLD_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pa_code        = (st == S_IDLE) ? '0 : ptab[idx];
  assign ramp_up_done   = (st == S_FULL);
  assign ramp_down_done = done_q;

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UP && $past(st) == S_UP) |-> (idx == $past(idx) || idx == $past(idx) + IDX_W'(1)));

  // R6
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DOWN && $past(st) == S_DOWN) |-> (idx == $past(idx) || idx == $past(idx) - IDX_W'(1)));

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (idx <= fin_q));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_down_done |-> (st == S_IDLE && $past(st) != S_IDLE && pa_code == '0));

  // R2
  single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_burst) |=> (ptab[0] == $past(wr_data)));

  // R3
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_burst |=> (ptr == '0));
endmodule

// File: tb/pa_ramp_seq_bench.sv
module pa_ramp_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_burst = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] final_idx = '0;
  logic [7:0] step_hold = '0;
  logic       tx_start = 1'b0, tx_end = 1'b0;
  logic [7:0] pa_code;
  logic       ramp_up_done, ramp_down_done;

  int checks = 0, fails = 0;
  logic [7:0] tm [8];
  int bptr = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pa_ramp_seq u_pa_ramp_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_burst(wr_burst), .wr_data(wr_data),
    .final_idx(final_idx), .step_hold(step_hold), .tx_start(tx_start), .tx_end(tx_end),
    .pa_code(pa_code), .ramp_up_done(ramp_up_done), .ramp_down_done(ramp_down_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_code(input string req, input int exp);
    check(pa_code == exp[7:0], req, pa_code, exp);
  endtask

  task automatic wr_single(input logic [7:0] d);
    wr_en = 1'b1; wr_burst = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    tm[0] = d;
  endtask

  task automatic burst_word(input logic [7:0] d);
    wr_en = 1'b1; wr_burst = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    tm[bptr] = d;
    bptr = (bptr + 1) % 8;
  endtask

  task automatic burst_close();
    wr_burst = 1'b0;
    @(negedge clk);
    bptr = 0;
  endtask

  task automatic pulse_start();
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic pulse_end();
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
  endtask

  task automatic ramp(input int fin, input int h, input int abort_at);
    int top;
    final_idx = fin[2:0]; step_hold = h[7:0];
    pulse_start();
    final_idx = 3'd7; step_hold = 8'd0;  // R4 values were captured at start
    top = fin;
    if (abort_at >= 0) begin
      for (int i = 0; i < abort_at; i++)
        for (int k = 0; k <= h; k++) begin chk_code("R4", tm[i]); @(negedge clk); end
      chk_code("R8", tm[abort_at]);
      pulse_end();
      top = abort_at;
    end else begin
      for (int i = 0; i < fin; i++)
        for (int k = 0; k <= h; k++) begin
          chk_code("R4", tm[i]);
          check(!ramp_up_done, "R5", ramp_up_done, 0);
          @(negedge clk);
        end
      chk_code(fin == 0 ? "R7" : "R4", tm[fin]);
      check(ramp_up_done, fin == 0 ? "R7" : "R5", ramp_up_done, 1);
      pulse_start();
      repeat (3) @(negedge clk);
      chk_code("R5", tm[fin]);
      check(ramp_up_done, "R5", ramp_up_done, 1);
      pulse_end();
      if (fin == 0) begin
        chk_code("R7", 0);
        check(ramp_down_done, "R7", ramp_down_done, 1);
        @(negedge clk);
        check(!ramp_down_done, "R7", ramp_down_done, 0);
        return;
      end
    end
    for (int i = top; i >= 0; i--)
      for (int k = 0; k <= h; k++) begin
        chk_code(abort_at >= 0 ? "R8" : "R6", tm[i]);
        check(!ramp_up_done && !ramp_down_done, "R6", ramp_up_done, 0);
        @(negedge clk);
      end
    chk_code("R6", 0);
    check(ramp_down_done, "R6", ramp_down_done, 1);
    @(negedge clk);
    check(!ramp_down_done, "R6", ramp_down_done, 0);
    chk_code("R1", 0);
  endtask

  task automatic test_reset();
    check(pa_code == 0, "R1", pa_code, 0);
    check(!ramp_up_done && !ramp_down_done, "R1", {ramp_up_done, ramp_down_done}, 0);
    for (int i = 0; i < 8; i++) tm[i] = '0;
    ramp(7, 0, -1);
  endtask

  task automatic test_idle_end();
    pulse_end();
    repeat (2) @(negedge clk);
    check(!ramp_down_done && pa_code == 0, "R9", pa_code, 0);
    check(!ramp_up_done, "R9", ramp_up_done, 0);
  endtask

  task automatic test_writes();
    for (int i = 0; i < 8; i++) burst_word(8'(16 * i + 3));
    burst_close();
    ramp(7, 0, -1);
    wr_single(8'hA5);
    wr_single(8'h5A);
    ramp(7, 0, -1);   // R2: upper entries untouched
    burst_word(8'h11); burst_word(8'h22); burst_close();
    burst_word(8'h33); burst_close();
    ramp(7, 0, -1);   // R3: second burst restarts at entry 0
    for (int i = 0; i < 9; i++) burst_word(8'(200 + i));
    burst_close();
    check(tm[0] == 8'd208, "R3", tm[0], 208);
    ramp(7, 0, -1);   // R3: wrap after entry 7
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle_end();
    test_writes();
    ramp(3, 2, -1);
    ramp(5, 1, -1);
    ramp(1, 4, -1);
    ramp(0, 3, -1);
    ramp(5, 2, 2);
    ramp(4, 0, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule